// File: doc/BRIEF.md
# Challenge-Response Authentication Sequencer

This block keeps a user design switched off until an external secure memory device proves that it holds the right per-device key. The only output that matters to the rest of the chip is `foe`. It comes up high, which holds the user design disabled, and it drops low only after one full authentication attempt succeeds. The user logic starts an attempt by raising `start`.

An attempt runs in five steps. The sequencer first reads the device's 64-bit unique serial number. It then asks a hash unit to derive the device key from the 64-bit secret (the parameter `SECRET`) and that serial number. Next it sends the device a random challenge, taken from a free-running LFSR at the moment the start edge is seen. It asks the hash unit for the expected answer, keyed with the derived device key over the same challenge. Finally it compares the device's answer with the expected answer. The hash engine and the serial-wire physical layer sit outside the block.

Both the device and the hash unit are reached through valid/ready request and response channels. A request (`*_req_valid` with its payload) is offered and held unchanged until the partner raises ready, and a transfer happens on any clock edge where valid and ready are both high. The sequencer raises `*_rsp_ready` only while it waits for that particular response. A response may therefore be stalled for any number of cycles, except that device answers are bounded by a timeout. A free-running prescaler set by `TICK_MHZ` (the clock frequency in MHz, at least 20) produces a one-microsecond tick, and the timeout is counted in those ticks.

Top module: `auth_seq`

## Requirements
- R1: After reset, `foe` is 1, and `dev_req_valid`, `dev_rsp_ready`, `hash_req_valid` and `hash_rsp_ready` are all 0.
- R2: An attempt starts only on a 0-to-1 change of `start` while the block is idle. Its first transfer is a device request with `dev_req_op` = 0, which reads the serial number. Holding `start` high starts no further attempt.
- R3: After the serial number arrives, the block issues a hash request with `hash_req_key` = `SECRET` and `hash_req_msg` = that serial number. The response is kept as the device key.
- R4: The second device request carries `dev_req_op` = 1, which marks a challenge. Its `dev_req_data` is the LFSR value captured at the start edge. That value is never zero, and it differs between two attempts started at different times.
- R5: After the device answers the challenge, the block issues a hash request with `hash_req_key` = the device key from R3 and `hash_req_msg` = the challenge.
- R6: `foe` falls in the cycle after the expected-answer response is taken, if that response equals the device's answer. On a mismatch, `foe` stays 1.
- R7: Once `foe` is 0 it stays 0 until reset, and later start edges issue no requests. A start edge during an attempt is ignored.
- R8: If a device request or response is not completed within `TIMEOUT_US` one-microsecond ticks (each tick `TICK_MHZ` cycles), the attempt is abandoned. All valids and readies go low, `foe` stays 1, no further hash request is made, and a new start edge can begin a fresh attempt.
- R9: Every request keeps its valid and its payload steady while ready is low, unless R8 aborts it. At most one request channel is valid at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | A rising edge requests an attempt |
| foe | output | 1 | 1 = user design disabled, 0 = authenticated |
| dev_req_valid | output | 1 | Device request valid |
| dev_req_ready | input | 1 | Device request ready |
| dev_req_op | output | 1 | 0 = read serial, 1 = challenge |
| dev_req_data | output | DW | Challenge value (0 when reading the serial) |
| dev_rsp_valid | input | 1 | Device response valid |
| dev_rsp_ready | output | 1 | Device response ready |
| dev_rsp_data | input | DW | Serial number or device answer |
| hash_req_valid | output | 1 | Hash request valid |
| hash_req_ready | input | 1 | Hash request ready |
| hash_req_key | output | DW | Hash key operand |
| hash_req_msg | output | DW | Hash message operand |
| hash_rsp_valid | input | 1 | Hash response valid |
| hash_rsp_ready | output | 1 | Hash response ready |
| hash_rsp_data | input | DW | Hash result |

## Verification
The bench uses a device whose stored key is wrong by one bit. A design that compares the wrong words, or drops `foe` before comparing, would enable the user design here. It uses a device that accepts the serial read and then never answers, and checks that the abort falls inside the microsecond window. A design with a broken prescaler or timeout would hang or abort early. It moves `start` low and high again while an attempt is running, and it also holds `start` high for a whole attempt. A design that retriggered would issue extra device requests. It also stalls every ready and response with extra latency, and compares the challenges of two attempts. This catches payloads that change under back-pressure and challenges that are not fresh.

// File: rtl/auth_pkg.sv
package auth_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SER_REQ,
    ST_SER_RSP,
    ST_KEY_REQ,
    ST_KEY_RSP,
    ST_CHL_REQ,
    ST_CHL_RSP,
    ST_EXP_REQ,
    ST_EXP_RSP
  } auth_state_t;

  localparam logic OP_READ_ID   = 1'b0;
  localparam logic OP_CHALLENGE = 1'b1;

endpackage

// File: rtl/auth_lfsr.sv
module auth_lfsr #(
  parameter int          W    = 64,
  parameter logic [W-1:0] SEED = 64'hACE1_2468_1357_BDF9,
  parameter logic [W-1:0] TAPS = 64'hD800_0000_0000_0000
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else if (state_q[0]) begin
      state_q <= (state_q >> 1) ^ TAPS;
    end else begin
      state_q <= state_q >> 1;
    end
  end

  assign value = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);  // R4

endmodule

// File: rtl/auth_timebase.sv
module auth_timebase #(
  parameter int TICK_MHZ = 50
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int              CW   = (TICK_MHZ > 1) ? $clog2(TICK_MHZ) : 1;
  localparam logic [CW-1:0]   LAST = CW'(TICK_MHZ - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);  // R8

endmodule

// File: rtl/auth_watch.sv
module auth_watch #(
  parameter int LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic expired
);

  localparam int            CW  = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == LIM);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);  // R8

endmodule

// File: rtl/auth_verdict.sv
module auth_verdict #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          judge,
  input  logic [DW-1:0] expected,
  input  logic [DW-1:0] answer,
  output logic          foe
);

  logic foe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      foe_q <= 1'b1;
    end else if (judge && expected == answer) begin
      foe_q <= 1'b0;
    end
  end

  assign foe = foe_q;

  AST_FOE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !foe_q |=> !foe_q);  // R7

endmodule

// File: rtl/auth_seq.sv
module auth_seq
  import auth_pkg::*;
#(
  parameter int           DW         = 64,
  parameter logic [DW-1:0] SECRET    = 64'h0F1E_2D3C_4B5A_6978,
  parameter int           TICK_MHZ   = 50,
  parameter int           TIMEOUT_US = 200,
  parameter logic [DW-1:0] LFSR_SEED = 64'hACE1_2468_1357_BDF9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          foe,
  output logic          dev_req_valid,
  input  logic          dev_req_ready,
  output logic          dev_req_op,
  output logic [DW-1:0] dev_req_data,
  input  logic          dev_rsp_valid,
  output logic          dev_rsp_ready,
  input  logic [DW-1:0] dev_rsp_data,
  output logic          hash_req_valid,
  input  logic          hash_req_ready,
  output logic [DW-1:0] hash_req_key,
  output logic [DW-1:0] hash_req_msg,
  input  logic          hash_rsp_valid,
  output logic          hash_rsp_ready,
  input  logic [DW-1:0] hash_rsp_data
);

  auth_state_t   state_q;
  logic          start_q;
  logic          start_rise;
  logic [DW-1:0] chal_q, serial_q, devkey_q, answer_q;
  logic [DW-1:0] lfsr_val;
  logic          tick, expired;
  logic          dev_phase, dev_hs, abort;
  logic          judge;

  auth_lfsr #(.W(DW), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .value(lfsr_val)
  );

  auth_timebase #(.TICK_MHZ(TICK_MHZ)) u_timebase (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  auth_watch #(.LIMIT(TIMEOUT_US)) u_watch (
    .clk(clk), .rst_n(rst_n), .clear(!dev_phase), .tick(tick), .expired(expired)
  );

  auth_verdict #(.DW(DW)) u_verdict (
    .clk(clk), .rst_n(rst_n), .judge(judge),
    .expected(hash_rsp_data), .answer(answer_q), .foe(foe)
  );

  // Channel drive decoded from the current step
  always_comb begin
    dev_req_valid  = (state_q == ST_SER_REQ) || (state_q == ST_CHL_REQ);
    dev_req_op     = (state_q == ST_CHL_REQ) ? OP_CHALLENGE : OP_READ_ID;
    dev_req_data   = (state_q == ST_CHL_REQ) ? chal_q : '0;
    dev_rsp_ready  = (state_q == ST_SER_RSP) || (state_q == ST_CHL_RSP);
    hash_req_valid = (state_q == ST_KEY_REQ) || (state_q == ST_EXP_REQ);
    hash_req_key   = (state_q == ST_KEY_REQ) ? SECRET : devkey_q;
    hash_req_msg   = (state_q == ST_KEY_REQ) ? serial_q : chal_q;
    hash_rsp_ready = (state_q == ST_KEY_RSP) || (state_q == ST_EXP_RSP);
  end

  assign start_rise = start && !start_q;
  assign dev_phase  = dev_req_valid || dev_rsp_ready;
  assign dev_hs     = (dev_req_valid && dev_req_ready) || (dev_rsp_ready && dev_rsp_valid);
  assign abort      = dev_phase && expired && !dev_hs;
  assign judge      = (state_q == ST_EXP_RSP) && hash_rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
    end else begin
      start_q <= start;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      chal_q   <= '0;
      serial_q <= '0;
      devkey_q <= '0;
      answer_q <= '0;
    end else if (abort) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_rise && foe) begin
            chal_q  <= lfsr_val;
            state_q <= ST_SER_REQ;
          end
        end
        ST_SER_REQ: if (dev_req_ready)  state_q <= ST_SER_RSP;
        ST_SER_RSP: begin
          if (dev_rsp_valid) begin
            serial_q <= dev_rsp_data;
            state_q  <= ST_KEY_REQ;
          end
        end
        ST_KEY_REQ: if (hash_req_ready) state_q <= ST_KEY_RSP;
        ST_KEY_RSP: begin
          if (hash_rsp_valid) begin
            devkey_q <= hash_rsp_data;
            state_q  <= ST_CHL_REQ;
          end
        end
        ST_CHL_REQ: if (dev_req_ready)  state_q <= ST_CHL_RSP;
        ST_CHL_RSP: begin
          if (dev_rsp_valid) begin
            answer_q <= dev_rsp_data;
            state_q  <= ST_EXP_REQ;
          end
        end
        ST_EXP_REQ: if (hash_req_ready) state_q <= ST_EXP_RSP;
        ST_EXP_RSP: if (hash_rsp_valid) state_q <= ST_IDLE;
        default:    state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DEV_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_req_valid && !dev_req_ready && !abort |=>
      dev_req_valid && $stable(dev_req_op) && $stable(dev_req_data));  // R9
  AST_HASH_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    hash_req_valid && !hash_req_ready |=>
      hash_req_valid && $stable(hash_req_key) && $stable(hash_req_msg));  // R9
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_req_valid && hash_req_valid));  // R9
  AST_FOE_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(foe) |-> $past(state_q == ST_EXP_RSP));  // R6
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !dev_req_valid && !dev_rsp_ready && !hash_req_valid && foe);  // R8
  AST_FIRST_READS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_req_valid) && $past(state_q == ST_IDLE) |-> dev_req_op == OP_READ_ID);  // R2

endmodule

// File: tb/auth_seq_bench.sv
module auth_seq_bench;

  localparam int          DW     = 64;
  localparam logic [63:0] SECRET = 64'h5A17_C3E9_0B44_D2F6;
  localparam int          MHZ    = 100;
  localparam int          TO_US  = 5;

  logic clk = 1'b0;
  logic rst_n, start, foe;
  logic dev_req_valid, dev_req_ready, dev_req_op, dev_rsp_valid, dev_rsp_ready;
  logic [DW-1:0] dev_req_data, dev_rsp_data;
  logic hash_req_valid, hash_req_ready, hash_rsp_valid, hash_rsp_ready;
  logic [DW-1:0] hash_req_key, hash_req_msg, hash_rsp_data;

  always #5 clk = ~clk;

  auth_seq #(.DW(DW), .SECRET(SECRET), .TICK_MHZ(MHZ), .TIMEOUT_US(TO_US)) u_auth_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .foe(foe),
    .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready),
    .dev_req_op(dev_req_op), .dev_req_data(dev_req_data),
    .dev_rsp_valid(dev_rsp_valid), .dev_rsp_ready(dev_rsp_ready), .dev_rsp_data(dev_rsp_data),
    .hash_req_valid(hash_req_valid), .hash_req_ready(hash_req_ready),
    .hash_req_key(hash_req_key), .hash_req_msg(hash_req_msg),
    .hash_rsp_valid(hash_rsp_valid), .hash_rsp_ready(hash_rsp_ready), .hash_rsp_data(hash_rsp_data)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // behaviour knobs for the partner models
  logic [63:0] dev_serial = 64'h0123_9ABC_4567_DEF0;
  logic [63:0] dev_stored;
  bit dev_silent = 0;
  int dev_stall = 0, dev_lat = 1, hash_stall = 0, hash_lat = 1;
  int hold_err = 0;

  // transaction logs
  logic        dlog_op  [0:31];
  logic [63:0] dlog_dat [0:31];
  logic [63:0] hlog_key [0:31];
  logic [63:0] hlog_msg [0:31];
  int dcnt = 0, hcnt = 0;

  function automatic logic [63:0] hf(input logic [63:0] k, input logic [63:0] m);
    logic [63:0] x;
    x = {k[40:0], k[63:41]} ^ m;
    return (x * 64'h9E37_79B9_7F4A_7C15) ^ {m[31:0], k[63:32]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // device model
  initial begin
    logic op;
    logic [63:0] d;
    dev_req_ready = 0; dev_rsp_valid = 0; dev_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (dev_req_valid) begin
        op = dev_req_op; d = dev_req_data;
        repeat (dev_stall) @(negedge clk);
        if (!dev_req_valid) continue;
        if (dev_req_op != op || dev_req_data != d) hold_err++;
        dev_req_ready = 1;
        @(negedge clk);
        dev_req_ready = 0;
        dlog_op[dcnt] = op; dlog_dat[dcnt] = d; dcnt++;
        if (!dev_silent) begin
          repeat (dev_lat) @(negedge clk);
          dev_rsp_valid = 1;
          dev_rsp_data  = op ? hf(dev_stored, d) : dev_serial;
          while (!dev_rsp_ready) @(negedge clk);
          @(negedge clk);
          dev_rsp_valid = 0;
        end
      end
    end
  end

  // hash unit model
  initial begin
    logic [63:0] k, m;
    hash_req_ready = 0; hash_rsp_valid = 0; hash_rsp_data = '0;
    forever begin
      @(negedge clk);
      if (hash_req_valid) begin
        k = hash_req_key; m = hash_req_msg;
        repeat (hash_stall) @(negedge clk);
        if (hash_req_key != k || hash_req_msg != m) hold_err++;
        hash_req_ready = 1;
        @(negedge clk);
        hash_req_ready = 0;
        hlog_key[hcnt] = k; hlog_msg[hcnt] = m; hcnt++;
        repeat (hash_lat) @(negedge clk);
        hash_rsp_valid = 1;
        hash_rsp_data  = hf(k, m);
        while (!hash_rsp_ready) @(negedge clk);
        @(negedge clk);
        hash_rsp_valid = 0;
      end
    end
  end

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (dev_req_valid || dev_rsp_ready || hash_req_valid || hash_rsp_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  logic [63:0] last_chal;

  task automatic t_reset();
    @(negedge clk);
    chk(foe == 1'b1, "R1 foe after reset", {63'd0, foe}, 64'd1);
    chk(!(dev_req_valid | dev_rsp_ready | hash_req_valid | hash_rsp_ready),
        "R1 channels idle", {60'd0, dev_req_valid, dev_rsp_ready, hash_req_valid, hash_rsp_ready}, 64'd0);
    repeat (10) @(negedge clk);
    chk(dcnt == 0, "R2 no request without start edge", 64'(dcnt), 64'd0);
  endtask

  task automatic t_bad_key();
    int d0 = dcnt, h0 = hcnt;
    dev_stored = hf(SECRET, dev_serial) ^ 64'd1;
    pulse_start();
    wait_idle();
    chk(dcnt == d0 + 2, "R2 two device transfers", 64'(dcnt - d0), 64'd2);
    chk(dlog_op[d0] == 1'b0, "R2 first op reads serial", {63'd0, dlog_op[d0]}, 64'd0);
    chk(hlog_key[h0] == SECRET, "R3 key hash key", hlog_key[h0], SECRET);
    chk(hlog_msg[h0] == dev_serial, "R3 key hash msg", hlog_msg[h0], dev_serial);
    chk(dlog_op[d0+1] == 1'b1, "R4 challenge op", {63'd0, dlog_op[d0+1]}, 64'd1);
    chk(dlog_dat[d0+1] != 0, "R4 challenge nonzero", dlog_dat[d0+1], 64'hFFFF_FFFF_FFFF_FFFF);
    chk(hlog_key[h0+1] == hf(SECRET, dev_serial), "R5 expected hash key",
        hlog_key[h0+1], hf(SECRET, dev_serial));
    chk(hlog_msg[h0+1] == dlog_dat[d0+1], "R5 expected hash msg", hlog_msg[h0+1], dlog_dat[d0+1]);
    chk(foe == 1'b1, "R6 mismatch keeps foe high", {63'd0, foe}, 64'd1);
    last_chal = dlog_dat[d0+1];
  endtask

  task automatic t_timeout();
    int d0 = dcnt, h0 = hcnt, t0, el;
    dev_silent = 1;
    @(negedge clk); start = 1;
    while (!dev_req_valid) @(negedge clk);
    t0 = cyc;
    start = 0;
    while (dev_req_valid || dev_rsp_ready) @(negedge clk);
    el = cyc - t0;
    chk(el >= (TO_US - 1) * MHZ && el <= TO_US * MHZ + 3, "R8 abort window",
        64'(el), 64'(TO_US * MHZ));
    repeat (5) @(negedge clk);
    chk(foe == 1'b1, "R8 foe high after abort", {63'd0, foe}, 64'd1);
    chk(hcnt == h0, "R8 no hash after abort", 64'(hcnt - h0), 64'd0);
    chk(dcnt == d0 + 1, "R8 one device transfer", 64'(dcnt - d0), 64'd1);
    dev_silent = 0;
  endtask

  task automatic t_friend_busy();
    int d0 = dcnt;
    dev_stored = hf(SECRET, dev_serial);
    dev_lat = 40;
    @(negedge clk); start = 1;
    while (dcnt < d0 + 1) @(negedge clk);
    start = 0;
    @(negedge clk); start = 1;
    wait_idle();
    start = 0;
    chk(dcnt == d0 + 2, "R7 busy edge and held start ignored", 64'(dcnt - d0), 64'd2);
    chk(foe == 1'b0, "R6 match drops foe", {63'd0, foe}, 64'd0);
    chk(dlog_dat[d0+1] != last_chal, "R4 fresh challenge", dlog_dat[d0+1], ~last_chal);
    dev_lat = 1;
  endtask

  task automatic t_sticky();
    int d0 = dcnt;
    pulse_start();
    repeat (20) @(negedge clk);
    chk(dcnt == d0, "R7 start after success ignored", 64'(dcnt - d0), 64'd0);
    chk(foe == 1'b0, "R7 foe stays low", {63'd0, foe}, 64'd0);
  endtask

  task automatic t_stall();
    int d0, h0;
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    chk(foe == 1'b1, "R1 reset restores foe", {63'd0, foe}, 64'd1);
    rst_n = 1;
    dev_stall = 6; dev_lat = 3; hash_stall = 4; hash_lat = 5;
    d0 = dcnt; h0 = hcnt;
    repeat (7) @(negedge clk);
    pulse_start();
    wait_idle();
    chk(hold_err == 0, "R9 payload held under back-pressure", 64'(hold_err), 64'd0);
    chk(dcnt == d0 + 2 && hcnt == h0 + 2, "R9 transfer counts",
        64'((dcnt - d0) * 16 + (hcnt - h0)), 64'h22);
    chk(hlog_msg[h0+1] == dlog_dat[d0+1], "R5 stalled expected msg", hlog_msg[h0+1], dlog_dat[d0+1]);
    chk(foe == 1'b0, "R6 stalled attempt succeeds", {63'd0, foe}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; start = 0;
    dev_stored = hf(SECRET, dev_serial);
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_bad_key();
    t_timeout();
    t_friend_busy();
    t_sticky();
    t_stall();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule